// File: doc/BRIEF.md
# Capture Reload Timer

This block is a 16-bit up-counter with a selectable prescaler and a capture unit. An edge on either of two external pins can latch the running count into a capture register. It can also reload the counter from a reload register at that same moment, which suits pulse-width and period measurement without software jitter. Software reaches the block through eight byte-wide registers on a simple write-enable, address and data port. Every register resets to zero.

Two operating variants sit on top of the basic capture. In live-read mode, capture is suppressed and the capture address pair returns the running count. In telegram mode, captures come in pairs. The first capture of a pair raises a first-event flag. The second capture clears that flag and raises the interrupt, but only when the captured value reaches a programmed minimum. Outside telegram mode, every capture raises the interrupt.

Top module: `crt_timer`

## Requirements
- R1: After the synchronous reset, all eight registers read 0x00 and `irq` is low.
- R2: The counter advances only while the run bit (control A bit 3) is 1. While the run bit is 0 the count holds, except when a capture reload occurs.
- R3: The prescaler restarts from zero whenever the counter is stopped. When the divider-width bit (control A bit 6) is 0, the counter advances once per 4 run clocks; when it is 1, once per 8. With N run clocks the count advances by floor(N/divisor).
- R4: When the extra-divide bit (control B bit 2) is 1, the divisor from R3 is multiplied by 8.
- R5: Incrementing past 0xFFFF wraps the count to 0x0000 and sets the overflow flag (control A bit 7). Only a write to control A with bit 7 equal to 0 clears the flag. Writing 1 leaves it unchanged. A hardware set in the same cycle as a clearing write wins.
- R6: The rising-edge enable (control A bit 2) and the falling-edge enable (control A bit 1) act independently. An edge of a disabled polarity captures nothing. Capture lands two to three clocks after the pin edge.
- R7: Control A bit 0 selects the capture source: 0 selects `cap_pin_a`, 1 selects `cap_pin_b`. Edges on the unselected pin have no effect.
- R8: When the reload enable (control A bit 4) is 1, a capture latches the old count and loads the counter from the reload registers in the same cycle.
- R9: When the live-read bit (control A bit 5) is 1, captures and reloads are suppressed and no interrupt is raised. Addresses 2 and 3 then read the running count. After the bit is cleared they read the last latched value again.
- R10: With telegram mode on (control B bit 0), captures toggle the first-event flag (control B bit 1). A capture that clears the flag raises `irq` only if the captured value is at least the minimum register. Software may clear the flag by writing 0 to it, and a hardware toggle wins over that write.
- R11: Outside telegram mode, each capture raises `irq` high for exactly one clock, one clock after the capture.
- R12: The register addresses are: 0/1 reload low/high, 2/3 capture low/high, 4/5 minimum low/high, 6 control A, 7 control B. Read data is registered and appears one clock after the address. Writes to addresses 2 and 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr` |
| cap_pin_a | input | 1 | Asynchronous capture input, source 0 |
| cap_pin_b | input | 1 | Asynchronous capture input, source 1 |
| irq | output | 1 | One-clock interrupt pulse |

## Verification
The bound checker watches, on every clock, the properties that can be stated cycle by cycle. These are: the count holding while stopped, the overflow flag staying set except under a clearing write, the capture register holding in live-read mode, the reload value arriving the cycle after a reloading capture, and the telegram interrupt coinciding with a cleared first-event flag and a capture at or above the minimum. The exact divide ratios, the source and polarity selection, the suppression of reloads in live-read mode, and the threshold boundary in telegram mode need whole scenarios, so the bench drives those through pin edges and register reads.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 16;

  localparam logic [ADDR_W-1:0] A_REL_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_REL_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_MIN_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_MIN_HI = 3'd5;
  localparam logic [ADDR_W-1:0] A_CTLA   = 3'd6;
  localparam logic [ADDR_W-1:0] A_CTLB   = 3'd7;

  // control A, bit 7 down to bit 0
  typedef struct packed {
    logic ovf;
    logic div8;
    logic live;
    logic rel_en;
    logic run;
    logic rise_en;
    logic fall_en;
    logic src_b;
  } ctla_t;

  localparam int CB_TELE  = 0;
  localparam int CB_FIRST = 1;
  localparam int CB_XDIV  = 2;
endpackage

// File: rtl/crt_sync_edge.sv
module crt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise,
  output logic fall
);
  localparam int SH_W = STAGES + 1;
  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SH_W-2:0], pin};
  end

  assign rise =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/crt_prescaler.sv
module crt_prescaler #(
  parameter int BASE_W = 3,
  parameter int XDIV_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic div8,
  input  logic xdiv,
  output logic tick
);
  localparam logic [BASE_W-1:0] MASK_LONG  = {BASE_W{1'b1}};
  localparam logic [BASE_W-1:0] MASK_SHORT = {1'b0, {(BASE_W-1){1'b1}}};
  localparam logic [XDIV_W-1:0] XDIV_LAST  = {XDIV_W{1'b1}};

  logic [BASE_W-1:0] base_q;
  logic [XDIV_W-1:0] ext_q;
  logic              base_wrap;

  assign base_wrap = (base_q == (div8 ? MASK_LONG : MASK_SHORT));
  assign tick      = run && base_wrap && (!xdiv || ext_q == XDIV_LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      base_q <= '0;
      ext_q  <= '0;
    end else begin
      base_q <= base_wrap ? '0 : base_q + 1'b1;
      if (base_wrap && xdiv) ext_q <= ext_q + 1'b1;
    end
  end
endmodule

// File: rtl/crt_capture_core.sv
module crt_capture_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             evt,
  input  logic             rel_en,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] min_val,
  input  logic             tele_en,
  input  logic             first_clr,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cap,
  output logic             first,
  output logic             ovf_hit,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic load;
  logic qualified;

  assign load      = evt && rel_en;
  assign ovf_hit   = tick && !load && (count == CNT_MAX);
  assign qualified = !tele_en || (first && count >= min_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      cap   <= '0;
      first <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (load)      count <= reload;
      else if (tick) count <= count + 1'b1;
      if (evt) cap <= count;
      if (evt && tele_en) first <= ~first;
      else if (first_clr) first <= 1'b0;
      irq <= evt && qualified;
    end
  end
endmodule

// File: rtl/crt_timer.sv
module crt_timer
  import crt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BASE_W      = 3,
  parameter int XDIV_W      = 3,
  parameter int N_SRC       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              cap_pin_a,
  input  logic              cap_pin_b,
  output logic              irq
);
  ctla_t            ctla_q;
  logic             tele_q;
  logic             xdiv_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] min_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] cap_q;
  logic             first_q;
  logic             ovf_hit;
  logic             tick;
  logic             cap_evt;
  logic             wr_a, wr_b;
  logic [N_SRC-1:0] pins, rise_v, fall_v;
  logic [BYTE_W-1:0] rd_next;
  logic [CNT_W-1:0] cap_view;

  assign pins = {cap_pin_b, cap_pin_a};
  assign wr_a = reg_we && reg_addr == A_CTLA;
  assign wr_b = reg_we && reg_addr == A_CTLB;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    crt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .pin (pins[g]),
      .rise(rise_v[g]),
      .fall(fall_v[g])
    );
  end

  assign cap_evt = !ctla_q.live &&
                   ((ctla_q.rise_en && rise_v[ctla_q.src_b]) ||
                    (ctla_q.fall_en && fall_v[ctla_q.src_b]));

  crt_prescaler #(.BASE_W(BASE_W), .XDIV_W(XDIV_W)) u_pre (
    .clk (clk),
    .rst (rst),
    .run (ctla_q.run),
    .div8(ctla_q.div8),
    .xdiv(xdiv_q),
    .tick(tick)
  );

  crt_capture_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .evt      (cap_evt),
    .rel_en   (ctla_q.rel_en),
    .reload   (reload_q),
    .min_val  (min_q),
    .tele_en  (tele_q),
    .first_clr(wr_b && !reg_wdata[CB_FIRST]),
    .count    (count_q),
    .cap      (cap_q),
    .first    (first_q),
    .ovf_hit  (ovf_hit),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctla_q   <= '0;
      tele_q   <= 1'b0;
      xdiv_q   <= 1'b0;
      reload_q <= '0;
      min_q    <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          A_REL_LO: reload_q[7:0]  <= reg_wdata;
          A_REL_HI: reload_q[15:8] <= reg_wdata;
          A_MIN_LO: min_q[7:0]     <= reg_wdata;
          A_MIN_HI: min_q[15:8]    <= reg_wdata;
          A_CTLB: begin
            tele_q <= reg_wdata[CB_TELE];
            xdiv_q <= reg_wdata[CB_XDIV];
          end
          default: ;
        endcase
      end
      if (wr_a) ctla_q[6:0] <= reg_wdata[6:0];
      if (ovf_hit)                   ctla_q.ovf <= 1'b1;
      else if (wr_a && !reg_wdata[7]) ctla_q.ovf <= 1'b0;
    end
  end

  assign cap_view = ctla_q.live ? count_q : cap_q;

  always_comb begin
    case (reg_addr)
      A_REL_LO: rd_next = reload_q[7:0];
      A_REL_HI: rd_next = reload_q[15:8];
      A_CAP_LO: rd_next = cap_view[7:0];
      A_CAP_HI: rd_next = cap_view[15:8];
      A_MIN_LO: rd_next = min_q[7:0];
      A_MIN_HI: rd_next = min_q[15:8];
      A_CTLA:   rd_next = ctla_q;
      default:  rd_next = {5'd0, xdiv_q, first_q, tele_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end
endmodule

// File: rtl/crt_timer_chk.sv
module crt_timer_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic [7:0]  reg_wdata,
  input logic        run_q,
  input logic        live_q,
  input logic        rel_en_q,
  input logic        ovf_q,
  input logic        tele_q,
  input logic        first_q,
  input logic        cap_evt,
  input logic        irq,
  input logic [15:0] count_q,
  input logic [15:0] cap_q,
  input logic [15:0] reload_q,
  input logic [15:0] min_q
);
  assert_freeze_R2: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !cap_evt) |=> $stable(count_q));

  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !(reg_we && reg_addr == 3'd6 && !reg_wdata[7])) |=> ovf_q);

  assert_reload_R8: assert property (@(posedge clk) disable iff (rst)
    (cap_evt && rel_en_q) |=> count_q == $past(reload_q));

  assert_live_hold_R9: assert property (@(posedge clk) disable iff (rst)
    live_q |=> $stable(cap_q));

  assert_tele_flag_R10: assert property (@(posedge clk) disable iff (rst)
    (irq && $past(tele_q)) |-> !first_q);

  assert_tele_min_R10: assert property (@(posedge clk) disable iff (rst)
    (irq && $past(tele_q)) |-> cap_q >= $past(min_q));
endmodule

bind crt_timer crt_timer_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .run_q    (ctla_q.run),
  .live_q   (ctla_q.live),
  .rel_en_q (ctla_q.rel_en),
  .ovf_q    (ctla_q.ovf),
  .tele_q   (tele_q),
  .first_q  (first_q),
  .cap_evt  (cap_evt),
  .irq      (irq),
  .count_q  (count_q),
  .cap_q    (cap_q),
  .reload_q (reload_q),
  .min_q    (min_q)
);

// File: tb/crt_timer_tb.sv
module crt_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       cap_pin_a = 1'b0;
  logic       cap_pin_b = 1'b0;
  logic       irq;

  int checks = 0;
  int failures = 0;
  int irq_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  crt_timer u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cap_pin_a(cap_pin_a), .cap_pin_b(cap_pin_b), .irq(irq)
  );

  always @(negedge clk) if (!rst && irq) irq_cnt++;

  // pre-mask for control A, extra-divide control B, run clocks, expected advance
  localparam logic [31:0] VEC [6] = '{
    {8'h00, 8'h00, 8'd40,  8'd10},
    {8'h40, 8'h00, 8'd40,  8'd5},
    {8'h00, 8'h04, 8'd64,  8'd2},
    {8'h40, 8'h04, 8'd128, 8'd2},
    {8'h00, 8'h00, 8'd7,   8'd1},
    {8'h40, 8'h00, 8'd15,  8'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; reg_we = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo);
    rd(a + 3'd1, hi);
    d = {hi, lo};
  endtask

  task automatic pin(input bit b, input logic v);
    if (b) cap_pin_b = v; else cap_pin_a = v;
    idle(4);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] c0, c1;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 / R12: reset values of every address
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), b);
      chk("R1 reset read", b, 8'h00);
    end
    chk("R1 irq low", irq, 1'b0);

    // R2 R3 R4: divide ratios from the vector table
    for (int i = 0; i < 6; i++) begin
      wr(3'd7, VEC[i][23:16]);
      wr(3'd6, 8'hA0 | VEC[i][31:24]);
      rd16(3'd2, c0);
      wr(3'd6, 8'hA8 | VEC[i][31:24]);
      idle(int'(VEC[i][15:8]) - 1);
      wr(3'd6, 8'hA0 | VEC[i][31:24]);
      rd16(3'd2, c1);
      chk("R3 R4 count advance", c1 - c0, {24'd0, VEC[i][7:0]});
      idle(10);
      rd16(3'd2, c0);
      chk("R2 frozen while stopped", c0, c1);
    end
    wr(3'd7, 8'h00);

    // R5 R8 R11: reload to near-max, then overflow
    wr(3'd0, 8'hFE); wr(3'd1, 8'hFF);
    wr(3'd6, 8'h94);
    irq_cnt = 0;
    pin(0, 1'b1);
    pin(0, 1'b0);
    chk("R11 one pulse per capture", irq_cnt, 1);
    rd(3'd6, b);
    chk("R5 write of 1 does not set flag", b, 8'h14);
    wr(3'd6, 8'h88);
    idle(7);
    wr(3'd6, 8'hA0);
    rd16(3'd2, c0);
    chk("R5 count wraps", c0, 16'h0000);
    rd(3'd6, b);
    chk("R5 overflow flag set", b, 8'hA0);
    wr(3'd6, 8'hA0);
    rd(3'd6, b);
    chk("R5 flag survives write of 1", b, 8'hA0);
    wr(3'd6, 8'h20);
    rd(3'd6, b);
    chk("R5 flag cleared by write of 0", b, 8'h20);

    // R6 R8: rising only, reload 0x1234
    wr(3'd0, 8'h34); wr(3'd1, 8'h12);
    wr(3'd6, 8'h14);
    irq_cnt = 0;
    pin(0, 1'b1);
    pin(0, 1'b0);
    chk("R6 falling edge ignored", irq_cnt, 1);
    rd16(3'd2, c0);
    chk("R6 captured old count", c0, 16'h0000);
    pin(0, 1'b1);
    pin(0, 1'b0);
    rd16(3'd2, c0);
    chk("R8 reload value captured next", c0, 16'h1234);
    wr(3'd2, 8'h55);
    rd16(3'd2, c0);
    chk("R12 capture write ignored", c0, 16'h1234);

    // R7 R6: source B, both edges
    wr(3'd0, 8'hAB); wr(3'd1, 8'h00);
    wr(3'd6, 8'h17);
    irq_cnt = 0;
    pin(0, 1'b1);
    pin(0, 1'b0);
    chk("R7 unselected pin no irq", irq_cnt, 0);
    rd16(3'd2, c0);
    chk("R7 unselected pin no capture", c0, 16'h1234);
    pin(1, 1'b1);
    rd16(3'd2, c0);
    chk("R7 source B rising capture", c0, 16'h1234);
    pin(1, 1'b0);
    rd16(3'd2, c0);
    chk("R6 falling capture when enabled", c0, 16'h00AB);
    chk("R11 two captures two pulses", irq_cnt, 2);

    // R9: live-read mode
    wr(3'd0, 8'h77); wr(3'd1, 8'h07);
    wr(3'd6, 8'h34);
    irq_cnt = 0;
    pin(0, 1'b1);
    pin(0, 1'b0);
    chk("R9 no irq in live mode", irq_cnt, 0);
    wr(3'd6, 8'h3C);
    idle(7);
    wr(3'd6, 8'h34);
    rd16(3'd2, c0);
    chk("R9 live count, no reload", c0, 16'h00AD);
    wr(3'd6, 8'h14);
    rd16(3'd2, c0);
    chk("R9 latched value returns", c0, 16'h00AB);

    // R10: telegram mode
    wr(3'd4, 8'h00); wr(3'd5, 8'h01);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    wr(3'd7, 8'h01);
    irq_cnt = 0;
    pin(0, 1'b1); pin(0, 1'b0);
    rd(3'd7, b);
    chk("R10 first flag set", b, 8'h03);
    chk("R10 no irq on first event", irq_cnt, 0);
    pin(0, 1'b1); pin(0, 1'b0);
    rd(3'd7, b);
    chk("R10 first flag cleared", b, 8'h01);
    chk("R10 below minimum no irq", irq_cnt, 0);
    wr(3'd1, 8'h02);
    pin(0, 1'b1); pin(0, 1'b0);
    pin(0, 1'b1); pin(0, 1'b0);
    chk("R10 above minimum irq", irq_cnt, 1);
    wr(3'd5, 8'h02);
    pin(0, 1'b1); pin(0, 1'b0);
    pin(0, 1'b1); pin(0, 1'b0);
    chk("R10 equal to minimum irq", irq_cnt, 2);
    pin(0, 1'b1); pin(0, 1'b0);
    wr(3'd7, 8'h01);
    rd(3'd7, b);
    chk("R10 software clear of flag", b, 8'h01);

    // R1: reset again mid-operation
    wr(3'd6, 8'h08);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), b);
      chk("R1 reset after use", b, 8'h00);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule